// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Logic

This block keeps the normal interrupt status word of an SD/MMC host controller, along with two 16-bit masks. The status-enable mask decides which events may be latched and which bits a read returns. The signal-enable mask decides which status bits may raise the single interrupt line. Ordinary event bits are set by one-cycle hardware pulses. Software clears them by writing ones. Bit 15 summarises a separate error status vector. Bit 8 mirrors the card's interrupt level. Bits 14 to 11 capture the moment the SD-side FIFO address arrives at one of four programmed thresholds.

Software reaches the block through a flat register port. The address and write-data inputs are sampled on the clock edge when the write strobe is high. Read data is a combinational function of the address. The interrupt output is combinational from the status word and the signal-enable mask, so it changes in the same cycle as the status.

Top module: `sdh_irq_status`

## Requirements
- R1: After synchronous reset every latched status bit and both masks are 0, so reads of offsets 0x30, 0x34 and 0x38 return 0 and `irq_o` is 0 while the error vector and the card level are 0.
- R2: A pulse on `evt_i[k]` latches a status bit on the next clock edge when the matching status-enable bit is 1. The mapping is `evt_i[7:0]` to bits 7..0, `evt_i[8]` to bit 9 and `evt_i[9]` to bit 10, where bit 10 is the read-wait event.
- R3: An event pulse that arrives while its status-enable bit is 0 is dropped, and setting the enable bit afterwards does not reveal it.
- R4: A write to offset 0x30 clears every clearable status bit (bits 0–7 and 9–14) whose data bit is 1. Bits written with 0 keep their value, and one write can clear several bits.
- R5: When a hardware set and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A read of offset 0x30 returns the status word ANDed with the status-enable mask, and the signal-enable mask has no effect on the read.
- R7: `irq_o` is 1 exactly when some status bit and its signal-enable bit are both 1, whatever the status-enable mask hides from reads.
- R8: Status bit 15 is 1 whenever any bit of `err_sts_i` is 1, and writing 1 to it has no effect.
- R9: Status bit 8 equals `card_irq_i`, and a write of 1 to it does not clear it while the card still asserts.
- R10: Bits 14, 13, 12 and 11 are set on the clock edge at which `fifo_addr_i` first becomes equal to threshold 3, 2, 1 and 0 respectively, where threshold i is `fifo_thr_i[i*FIFO_AW +: FIFO_AW]`. An address that stays equal does not set the bit again after it is cleared.
- R11: Offset 0x34 holds the status-enable mask and offset 0x38 holds the signal-enable mask, and both read back as written. Writes to any other offset change nothing, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset for reads and writes |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| evt_i | input | 10 | One-cycle event pulses for the ordinary status bits |
| err_sts_i | input | ERR_W | Error status vector that is summarised into bit 15 |
| card_irq_i | input | 1 | Card interrupt level |
| fifo_addr_i | input | FIFO_AW | SD-side FIFO address |
| fifo_thr_i | input | 4*FIFO_AW | Four packed FIFO interrupt thresholds, threshold 0 in the low slice |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `evt_i` pulses last one cycle and that the FIFO thresholds stay still while the address moves. They also assume that the register address is stable from one falling edge to the next. The bench keeps to these assumptions by driving every input at the falling edge. It holds the thresholds constant for the whole run and raises each event for exactly one cycle. The error and card inputs change only between register accesses, so the level-following bits are always seen after they have settled.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int STS_W     = 16;
    localparam int REG_AW    = 8;
    localparam int NUM_EVT   = 10;
    localparam int NUM_THR   = 4;
    localparam int BIT_CARD  = 8;
    localparam int BIT_RWAIT = 10;
    localparam int BIT_FIFO0 = 11;
    localparam int BIT_ERR   = 15;

    localparam logic [REG_AW-1:0] OFS_STS    = 8'h30;
    localparam logic [REG_AW-1:0] OFS_STS_EN = 8'h34;
    localparam logic [REG_AW-1:0] OFS_SIG_EN = 8'h38;

    // bits that are latched and cleared by writing one
    localparam logic [STS_W-1:0] W1C_MASK = 16'h7EFF;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STS,
        SEL_STS_EN,
        SEL_SIG_EN
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] addr;
        logic [STS_W-1:0]  data;
    } reg_req_t;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_STS:    s = SEL_STS;
            OFS_STS_EN: s = SEL_STS_EN;
            OFS_SIG_EN: s = SEL_SIG_EN;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [STS_W-1:0] evt_to_word(input logic [NUM_EVT-1:0] e);
        logic [STS_W-1:0] w;
        w           = '0;
        w[7:0]      = e[7:0];
        w[9]        = e[8];
        w[BIT_RWAIT] = e[9];
        return w;
    endfunction

    function automatic logic [STS_W-1:0] fifo_to_word(input logic [NUM_THR-1:0] h);
        logic [STS_W-1:0] w;
        w = '0;
        w[BIT_FIFO0 +: NUM_THR] = h;
        return w;
    endfunction

endpackage

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs
    import sdh_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    output logic [STS_W-1:0] sts_en_o,
    output logic [STS_W-1:0] sig_en_o,
    output logic [STS_W-1:0] sts_clr_o,
    output reg_sel_e         sel_o
);

    assign sel_o = decode_addr(req.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_en_o <= '0;
            sig_en_o <= '0;
        end else if (req.wr) begin
            case (sel_o)
                SEL_STS_EN: sts_en_o <= req.data;
                SEL_SIG_EN: sig_en_o <= req.data;
                default: ;
            endcase
        end
    end

    assign sts_clr_o = (req.wr && sel_o == SEL_STS) ? (req.data & W1C_MASK) : '0;

    // R11: masks move only on a write to their own offset
    a_r11_sts_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_STS_EN) |=> $stable(sts_en_o));
    a_r11_sig_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_SIG_EN) |=> $stable(sig_en_o));
    // R4: clearing only comes from a status write
    a_r4_clr_needs_write: assert property (@(posedge clk) disable iff (rst)
        (|sts_clr_o) |-> (req.wr && req.addr == OFS_STS));

endmodule

// File: rtl/sdh_irq_fifo_thr.sv
module sdh_irq_fifo_thr #(
    parameter int AW = 10,
    parameter int N  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic [N*AW-1:0] thr_i,
    output logic [N-1:0]  rise_o
);

    for (genvar g = 0; g < N; g++) begin : g_thr
        logic hit;
        logic hit_q;

        assign hit = (addr_i == thr_i[g*AW +: AW]);

        always_ff @(posedge clk) begin
            if (rst) hit_q <= 1'b0;
            else     hit_q <= hit;
        end

        assign rise_o[g] = hit & ~hit_q;

        // R10: an arrival event implies the address sits on the threshold
        a_r10_rise_match: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |-> (addr_i == thr_i[g*AW +: AW]));
        // R10: one event per arrival
        a_r10_no_repeat: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/sdh_irq_evt_bits.sv
module sdh_irq_evt_bits #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q_o[g] <= 1'b0;
            else     q_o[g] <= (q_o[g] & ~clr_i[g]) | set_i[g];
        end

        // R5: a set survives a simultaneous clear
        a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> q_o[g]);
        // R4: a lone clear empties the bit
        a_r4_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !set_i[g]) |=> !q_o[g]);
        // R4: nothing pending means the bit holds
        a_r4_hold: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[g] && !set_i[g]) |=> $stable(q_o[g]));
    end

endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int FIFO_AW = 10,
    parameter int ERR_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr_i,
    input  logic [REG_AW-1:0]          reg_addr_i,
    input  logic [STS_W-1:0]           reg_wdata_i,
    output logic [STS_W-1:0]           reg_rdata_o,
    input  logic [NUM_EVT-1:0]         evt_i,
    input  logic [ERR_W-1:0]           err_sts_i,
    input  logic                       card_irq_i,
    input  logic [FIFO_AW-1:0]         fifo_addr_i,
    input  logic [NUM_THR*FIFO_AW-1:0] fifo_thr_i,
    output logic                       irq_o
);

    reg_req_t         req;
    reg_sel_e         sel;
    logic [STS_W-1:0] sts_en;
    logic [STS_W-1:0] sig_en;
    logic [STS_W-1:0] sts_clr;
    logic [STS_W-1:0] sts_set;
    logic [STS_W-1:0] latched;
    logic [STS_W-1:0] status_word;
    logic [NUM_THR-1:0] fifo_rise;

    assign req = '{wr: reg_wr_i, addr: reg_addr_i, data: reg_wdata_i};

    sdh_irq_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sts_en_o  (sts_en),
        .sig_en_o  (sig_en),
        .sts_clr_o (sts_clr),
        .sel_o     (sel)
    );

    sdh_irq_fifo_thr #(
        .AW (FIFO_AW),
        .N  (NUM_THR)
    ) i_fifo_thr (
        .clk    (clk),
        .rst    (rst),
        .addr_i (fifo_addr_i),
        .thr_i  (fifo_thr_i),
        .rise_o (fifo_rise)
    );

    assign sts_set = (evt_to_word(evt_i) | fifo_to_word(fifo_rise)) & sts_en & W1C_MASK;

    sdh_irq_evt_bits #(
        .W (STS_W)
    ) i_evt_bits (
        .clk   (clk),
        .rst   (rst),
        .set_i (sts_set),
        .clr_i (sts_clr),
        .q_o   (latched)
    );

    always_comb begin
        status_word           = latched & W1C_MASK;
        status_word[BIT_CARD] = card_irq_i;
        status_word[BIT_ERR]  = |err_sts_i;
    end

    always_comb begin
        case (sel)
            SEL_STS:    reg_rdata_o = status_word & sts_en;
            SEL_STS_EN: reg_rdata_o = sts_en;
            SEL_SIG_EN: reg_rdata_o = sig_en;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_word & sig_en);

    // R6: a status read never shows a bit whose status enable is 0
    a_r6_read_masked: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == OFS_STS) |-> ((reg_rdata_o & ~sts_en) == '0));
    // R8: an error with its signal enable raises the interrupt
    a_r8_err_irq: assert property (@(posedge clk) disable iff (rst)
        ((|err_sts_i) && sig_en[BIT_ERR]) |-> irq_o);
    // R9: the card level is visible while enabled
    a_r9_card_read: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == OFS_STS && sts_en[BIT_CARD] && card_irq_i) |-> reg_rdata_o[BIT_CARD]);
    // R7: no enabled source means no interrupt
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (sig_en == '0) |-> !irq_o);

endmodule

// File: tb/test_sdh_irq_status.sv
module test_sdh_irq_status;

    localparam int AW = 4;
    localparam int EW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [9:0]  evt = '0;
    logic [EW-1:0] err = '0;
    logic        card = 1'b0;
    logic [AW-1:0] faddr = '0;
    logic [4*AW-1:0] fthr = {4'd12, 4'd9, 4'd7, 4'd3};
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sdh_irq_status #(.FIFO_AW(AW), .ERR_W(EW)) i_sdh_irq_status (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .err_sts_i   (err),
        .card_irq_i  (card),
        .fifo_addr_i (faddr),
        .fifo_thr_i  (fthr),
        .irq_o       (irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        #1;
        chk({15'd0, irq}, {15'd0, exp}, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic int evt_pos(input int i);
        return (i < 8) ? i : i + 1;
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h30, 16'h0000, "R1 status");
        rd(8'h34, 16'h0000, "R1 sts_en");
        rd(8'h38, 16'h0000, "R1 sig_en");
        irq_chk(1'b0, "R1 irq");

        // R11 mask registers and stray offsets
        wr(8'h34, 16'hFFFF);
        wr(8'h38, 16'hA5C3);
        rd(8'h34, 16'hFFFF, "R11 sts_en readback");
        rd(8'h38, 16'hA5C3, "R11 sig_en readback");
        wr(8'h3C, 16'h1234);
        wr(8'h31, 16'hFFFF);
        rd(8'h34, 16'hFFFF, "R11 sts_en after stray write");
        rd(8'h38, 16'hA5C3, "R11 sig_en after stray write");
        rd(8'h3C, 16'h0000, "R11 stray read");
        wr(8'h38, 16'h0000);

        // R2 / R4 each event bit set then cleared
        for (int i = 0; i < 10; i++) begin
            pulse(10'(1 << i));
            rd(8'h30, 16'(1 << evt_pos(i)), "R2 event latch");
            wr(8'h30, 16'(1 << evt_pos(i)));
            rd(8'h30, 16'h0000, "R4 single clear");
        end

        // R4 zero write keeps, multi clear
        pulse(10'h3FF);
        rd(8'h30, 16'h06FF, "R2 all events");
        wr(8'h30, 16'h0000);
        rd(8'h30, 16'h06FF, "R4 zero write keeps");
        wr(8'h30, 16'h0405);
        rd(8'h30, 16'h02FA, "R4 multi clear");

        // R6 read masking sweep, signal enable irrelevant
        wr(8'h38, 16'hFFFF);
        pulse(10'h3FF);
        for (int k = 0; k < 16; k++) begin
            wr(8'h34, 16'(1 << k));
            rd(8'h30, 16'h06FF & 16'(1 << k), "R6 one-hot status enable");
        end
        wr(8'h34, 16'h0F0F);
        rd(8'h30, 16'h060F, "R6 pattern enable");
        wr(8'h38, 16'h0000);
        rd(8'h30, 16'h060F, "R6 signal enable no effect");

        // R7 irq vs signal enable, independent of read masking
        wr(8'h34, 16'h0000);
        for (int k = 0; k < 16; k++) begin
            wr(8'h38, 16'(1 << k));
            irq_chk((16'h06FF >> k) & 1'b1, "R7 irq per signal enable bit");
        end
        rd(8'h30, 16'h0000, "R7 hidden from read");

        // R3 events dropped while disabled
        wr(8'h34, 16'hFFFF);
        wr(8'h30, 16'hFFFF);
        wr(8'h34, 16'h0000);
        pulse(10'h3FF);
        wr(8'h34, 16'hFFFF);
        rd(8'h30, 16'h0000, "R3 dropped events");
        wr(8'h38, 16'hFFFF);
        irq_chk(1'b0, "R3 irq quiet");
        wr(8'h38, 16'h0000);

        // R5 set beats clear
        pulse(10'h003);
        @(negedge clk);
        evt = 10'h001; reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 16'h0003;
        @(negedge clk);
        evt = '0; reg_wr = 1'b0;
        rd(8'h30, 16'h0001, "R5 set wins");
        wr(8'h30, 16'h0001);

        // R8 error summary over full vector
        wr(8'h38, 16'h8000);
        for (int v = 0; v < 256; v++) begin
            err = EW'(v);
            rd(8'h30, (v != 0) ? 16'h8000 : 16'h0000, "R8 error summary");
            irq_chk(v != 0, "R8 error irq");
        end
        err = 8'h40;
        wr(8'h30, 16'h8000);
        rd(8'h30, 16'h8000, "R8 write ignored");
        err = '0;
        wr(8'h38, 16'h0000);

        // R9 card level
        card = 1'b1;
        rd(8'h30, 16'h0100, "R9 card set");
        wr(8'h30, 16'h0100);
        rd(8'h30, 16'h0100, "R9 card not cleared by write");
        card = 1'b0;
        rd(8'h30, 16'h0000, "R9 card follows level");

        // R10 FIFO thresholds sweep: thr0=3 thr1=7 thr2=9 thr3=12
        for (int a = 0; a < 16; a++) begin
            logic [15:0] e;
            @(negedge clk);
            faddr = AW'(a);
            @(negedge clk);
            e = '0;
            if (a >= 3)  e[11] = 1'b1;
            if (a >= 7)  e[12] = 1'b1;
            if (a >= 9)  e[13] = 1'b1;
            if (a >= 12) e[14] = 1'b1;
            rd(8'h30, e, "R10 threshold sweep");
        end
        wr(8'h30, 16'h7800);
        rd(8'h30, 16'h0000, "R10 cleared");
        @(negedge clk);
        faddr = 4'd12;
        repeat (3) @(negedge clk);
        rd(8'h30, 16'h4000, "R10 arrive thr3");
        wr(8'h30, 16'h4000);
        repeat (3) @(negedge clk);
        rd(8'h30, 16'h0000, "R10 no re-set while holding");
        @(negedge clk);
        faddr = 4'd11;
        @(negedge clk);
        faddr = 4'd12;
        @(negedge clk);
        rd(8'h30, 16'h4000, "R10 re-arrival sets");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule